// File: doc/BRIEF.md
# UART Modem Control and Loopback

This block holds the 8-bit modem control register of one channel of a 16550-style UART, together with the logic that register steers. It drives the active-low modem control pins and places the channel in internal loopback. It chooses between the plain serial path and an infrared path, and it produces the clock enable that feeds the baud generator, either on every input clock or on one clock in four.

The host writes the register through a one-cycle write strobe and can read it back at any time. Every output of the block is a combinational function of the register contents and the live inputs, so a write takes effect on the clock edge that captures it.

In loopback mode the channel is cut off from the outside world. The transmit pin rests at its idle level and the transmit shift output feeds the receive input directly. The four modem status lines seen by the status logic come from register bits, and the external control pins fall back to their inactive high level.

Top module: `uart_mctl`

## Requirements
- R1: After reset the register reads 0x00, the pins `dtr_n_pin`, `rts_n_pin` and `op2_n_pin` are 1, `tx_pin` is 1, `irda_sel` is 0, and `baud_tick_en` is 1 on every cycle.
- R2: On the clock edge where `wr_en` is 1, the register takes `wr_data`, and `rd_data` shows exactly that value from then on until the next write or reset.
- R3: When loopback bit 4 is 0, `dtr_n_pin` is the inverse of bit 0 and `rts_n_pin` is the inverse of bit 1.
- R4: When bit 4 is 0 and `op2_pin_fn` is 2'b00, `op2_n_pin` is the inverse of bit 3. For any other `op2_pin_fn` value, `op2_n_pin` is 1.
- R5: When bit 4 is 1, `dtr_n_pin`, `rts_n_pin` and `op2_n_pin` are all 1, whatever the other register bits hold.
- R6: When bit 4 is 1, the active-high status outputs follow register bits and ignore the external status pins, as follows: `dsr_st` follows bit 0, `cts_st` follows bit 1, `ri_st` follows bit 2 and `dcd_st` follows bit 3.
- R7: When bit 4 is 0, each active-high status output is the inverse of its active-low input pin: `cts_n_pin`, `dsr_n_pin`, `ri_n_pin` or `dcd_n_pin`.
- R8: When bit 4 is 1, `rx_to_shift` equals `tx_shift`, `rx_pin` and `irda_rx_dec` are ignored, and `tx_pin` holds the idle level.
- R9: When bit 6 is 1 and bit 4 is 0, `tx_pin` carries `irda_tx_enc` and `rx_to_shift` carries `irda_rx_dec`. `irda_sel` equals bit 6. When bit 6 is 0 and bit 4 is 0, `tx_pin` carries `tx_shift` and `rx_to_shift` carries `rx_pin`.
- R10: The idle level of `tx_pin` is 1 with bit 6 clear and 0 with bit 6 set.
- R11: With bit 7 set, `baud_tick_en` is 1 for one cycle in every four. Its first pulse falls in the fourth cycle after the edge that sets bit 7.
- R12: Clearing bit 7 restores `baud_tick_en` to 1 on every cycle, starting in the cycle right after the write, and resets the divide phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Input clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 8 | Register write value |
| rd_data | output | 8 | Register readback |
| op2_pin_fn | input | 2 | Pin function select; 00 gives the pin to OP2 |
| tx_shift | input | 1 | Serial output of the transmit shifter |
| irda_tx_enc | input | 1 | Output of the infrared pulse encoder |
| rx_pin | input | 1 | External serial input |
| irda_rx_dec | input | 1 | Output of the infrared pulse decoder |
| cts_n_pin | input | 1 | External clear-to-send, active low |
| dsr_n_pin | input | 1 | External data-set-ready, active low |
| ri_n_pin | input | 1 | External ring indicator, active low |
| dcd_n_pin | input | 1 | External carrier detect, active low |
| tx_pin | output | 1 | External serial output |
| rx_to_shift | output | 1 | Serial input to the receive shifter |
| irda_sel | output | 1 | Routes the shifters through the infrared codec |
| dtr_n_pin | output | 1 | Data-terminal-ready pin, active low |
| rts_n_pin | output | 1 | Request-to-send pin, active low |
| op2_n_pin | output | 1 | General output 2 pin, active low |
| cts_st | output | 1 | Clear-to-send seen by status logic |
| dsr_st | output | 1 | Data-set-ready seen by status logic |
| ri_st | output | 1 | Ring indicator seen by status logic |
| dcd_st | output | 1 | Carrier detect seen by status logic |
| baud_tick_en | output | 1 | Clock enable for the baud generator |

## Verification
The assertions assume that `wr_en` and `wr_data` are stable around the sampling edge and free of X after reset. They also assume that `op2_pin_fn` changes only between clock edges, because several checks read the register back through `rd_data` in the same cycle as the pins. The bench drives every input on the falling edge and holds `wr_en` high for exactly one rising edge per write. The tick-spacing check is guarded against cycles that carry a write, so a change of divide mode never counts as a broken pulse spacing.

// File: rtl/uart_mctl_pkg.sv
package uart_mctl_pkg;

  typedef struct packed {
    logic presc_div4;
    logic irda_en;
    logic xon_any;
    logic loop_en;
    logic op2;
    logic op1;
    logic rts;
    logic dtr;
  } mctl_reg_t;

  typedef struct packed {
    logic cts;
    logic dsr;
    logic ri;
    logic dcd;
  } mstat_t;

  // Idle level of the serial output for a chosen path.
  function automatic logic tx_idle_level(input logic irda);
    return irda ? 1'b0 : 1'b1;
  endfunction

  // Active-low pin drive from a control bit, with a forced-off override.
  function automatic logic pin_drive_n(input logic bit_val, input logic force_off);
    return force_off ? 1'b1 : ~bit_val;
  endfunction

  // Next value of a wrapping phase counter.
  function automatic int unsigned phase_next(input int unsigned cur, input int unsigned ratio);
    return (cur + 1 >= ratio) ? 0 : cur + 1;
  endfunction

endpackage

// File: rtl/uart_mctl_reg.sv
module uart_mctl_reg
  import uart_mctl_pkg::*;
#(
  parameter int unsigned REG_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [REG_W-1:0] wr_data,
  output mctl_reg_t        mctl_q
);
  logic [REG_W-1:0] store_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     store_q <= '0;
    else if (wr_en) store_q <= wr_data;
  end

  assign mctl_q = mctl_reg_t'(store_q);
endmodule

// File: rtl/uart_mctl_route.sv
module uart_mctl_route
  import uart_mctl_pkg::*;
#(
  parameter int unsigned FN_W      = 2,
  parameter int unsigned N_STATUS  = 4
) (
  input  logic                loop_en,
  input  logic                irda_en,
  input  logic                dtr_bit,
  input  logic                rts_bit,
  input  logic                op1_bit,
  input  logic                op2_bit,
  input  logic [FN_W-1:0]     op2_pin_fn,
  input  logic                tx_shift,
  input  logic                irda_tx_enc,
  input  logic                rx_pin,
  input  logic                irda_rx_dec,
  input  logic [N_STATUS-1:0] stat_n_pins,
  output logic                tx_pin,
  output logic                rx_to_shift,
  output logic                dtr_n_pin,
  output logic                rts_n_pin,
  output logic                op2_n_pin,
  output logic [N_STATUS-1:0] stat_active
);
  localparam logic [FN_W-1:0] FN_OP2 = '0;

  logic                op2_owned;
  logic                path_tx;
  logic                path_rx;
  logic [N_STATUS-1:0] loop_src;

  assign op2_owned = (op2_pin_fn == FN_OP2);

  // Control pins: forced inactive during loopback.
  assign dtr_n_pin = pin_drive_n(dtr_bit, loop_en);
  assign rts_n_pin = pin_drive_n(rts_bit, loop_en);
  assign op2_n_pin = pin_drive_n(op2_bit, loop_en | ~op2_owned);

  // Serial path selection.
  assign path_tx     = irda_en ? irda_tx_enc : tx_shift;
  assign path_rx     = irda_en ? irda_rx_dec : rx_pin;
  assign tx_pin      = loop_en ? tx_idle_level(irda_en) : path_tx;
  assign rx_to_shift = loop_en ? tx_shift : path_rx;

  // Loopback sources in mstat_t order: cts, dsr, ri, dcd.
  assign loop_src = {rts_bit, dtr_bit, op1_bit, op2_bit};

  for (genvar g = 0; g < N_STATUS; g++) begin : g_stat
    assign stat_active[g] = loop_en ? loop_src[g] : ~stat_n_pins[g];
  end
endmodule

// File: rtl/uart_mctl_presc.sv
module uart_mctl_presc
  import uart_mctl_pkg::*;
#(
  parameter int unsigned RATIO = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic div_en,
  output logic tick_en
);
  localparam int unsigned CNT_W = (RATIO > 1) ? $clog2(RATIO) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(RATIO - 1);

  logic [CNT_W-1:0] phase_q;
  logic             at_last;

  assign at_last = (phase_q == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       phase_q <= '0;
    else if (!div_en) phase_q <= '0;
    else              phase_q <= CNT_W'(phase_next(int'(phase_q), RATIO));
  end

  assign tick_en = div_en ? at_last : 1'b1;
endmodule

// File: rtl/uart_mctl.sv
module uart_mctl
  import uart_mctl_pkg::*;
#(
  parameter int unsigned REG_W       = 8,
  parameter int unsigned FN_W        = 2,
  parameter int unsigned PRESC_RATIO = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [REG_W-1:0] wr_data,
  output logic [REG_W-1:0] rd_data,
  input  logic [FN_W-1:0]  op2_pin_fn,
  input  logic             tx_shift,
  input  logic             irda_tx_enc,
  input  logic             rx_pin,
  input  logic             irda_rx_dec,
  input  logic             cts_n_pin,
  input  logic             dsr_n_pin,
  input  logic             ri_n_pin,
  input  logic             dcd_n_pin,
  output logic             tx_pin,
  output logic             rx_to_shift,
  output logic             irda_sel,
  output logic             dtr_n_pin,
  output logic             rts_n_pin,
  output logic             op2_n_pin,
  output logic             cts_st,
  output logic             dsr_st,
  output logic             ri_st,
  output logic             dcd_st,
  output logic             baud_tick_en
);
  localparam int unsigned N_STATUS = $bits(mstat_t);

  mctl_reg_t mctl_q;
  mstat_t    stat_n_in;
  mstat_t    stat_out;

  uart_mctl_reg #(.REG_W(REG_W)) u_reg (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .wr_data (wr_data),
    .mctl_q  (mctl_q)
  );

  assign stat_n_in = '{cts: cts_n_pin, dsr: dsr_n_pin, ri: ri_n_pin, dcd: dcd_n_pin};

  uart_mctl_route #(.FN_W(FN_W), .N_STATUS(N_STATUS)) u_route (
    .loop_en     (mctl_q.loop_en),
    .irda_en     (mctl_q.irda_en),
    .dtr_bit     (mctl_q.dtr),
    .rts_bit     (mctl_q.rts),
    .op1_bit     (mctl_q.op1),
    .op2_bit     (mctl_q.op2),
    .op2_pin_fn  (op2_pin_fn),
    .tx_shift    (tx_shift),
    .irda_tx_enc (irda_tx_enc),
    .rx_pin      (rx_pin),
    .irda_rx_dec (irda_rx_dec),
    .stat_n_pins (stat_n_in),
    .tx_pin      (tx_pin),
    .rx_to_shift (rx_to_shift),
    .dtr_n_pin   (dtr_n_pin),
    .rts_n_pin   (rts_n_pin),
    .op2_n_pin   (op2_n_pin),
    .stat_active (stat_out)
  );

  uart_mctl_presc #(.RATIO(PRESC_RATIO)) u_presc (
    .clk     (clk),
    .rst_n   (rst_n),
    .div_en  (mctl_q.presc_div4),
    .tick_en (baud_tick_en)
  );

  assign rd_data  = REG_W'(mctl_q);
  assign irda_sel = mctl_q.irda_en;
  assign cts_st   = stat_out.cts;
  assign dsr_st   = stat_out.dsr;
  assign ri_st    = stat_out.ri;
  assign dcd_st   = stat_out.dcd;
endmodule

// File: rtl/uart_mctl_chk.sv
module uart_mctl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       wr_en,
  input logic [7:0] wr_data,
  input logic [7:0] rd_data,
  input logic [1:0] op2_pin_fn,
  input logic       tx_shift,
  input logic       tx_pin,
  input logic       rx_to_shift,
  input logic       dtr_n_pin,
  input logic       rts_n_pin,
  input logic       op2_n_pin,
  input logic       cts_st,
  input logic       dsr_st,
  input logic       ri_st,
  input logic       dcd_st,
  input logic       baud_tick_en
);
  AST_WRITE_READBACK: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> rd_data == $past(wr_data)); // R2

  AST_DTR_RTS_POLARITY: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_data[4] |-> (dtr_n_pin != rd_data[0]) && (rts_n_pin != rd_data[1])); // R3

  AST_OP2_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
    (op2_pin_fn != 2'b00) |-> op2_n_pin); // R4

  AST_LOOP_PINS_INACTIVE: assert property (@(posedge clk) disable iff (!rst_n)
    rd_data[4] |-> (dtr_n_pin && rts_n_pin && op2_n_pin)); // R5

  AST_LOOP_STATUS_MAP: assert property (@(posedge clk) disable iff (!rst_n)
    rd_data[4] |-> ({cts_st, dsr_st, ri_st, dcd_st} == {rd_data[1], rd_data[0], rd_data[2], rd_data[3]})); // R6

  AST_LOOP_RX_FEED: assert property (@(posedge clk) disable iff (!rst_n)
    rd_data[4] |-> (rx_to_shift == tx_shift)); // R8

  AST_LOOP_TX_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    rd_data[4] |-> (tx_pin == !rd_data[6])); // R10

  AST_TICK_SPACING: assert property (@(posedge clk) disable iff (!rst_n)
    (baud_tick_en && rd_data[7] && !wr_en) |=> !baud_tick_en); // R11

  AST_UNDIVIDED_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_data[7] |-> baud_tick_en); // R12
endmodule

bind uart_mctl uart_mctl_chk u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .wr_en        (wr_en),
  .wr_data      (wr_data),
  .rd_data      (rd_data),
  .op2_pin_fn   (op2_pin_fn),
  .tx_shift     (tx_shift),
  .tx_pin       (tx_pin),
  .rx_to_shift  (rx_to_shift),
  .dtr_n_pin    (dtr_n_pin),
  .rts_n_pin    (rts_n_pin),
  .op2_n_pin    (op2_n_pin),
  .cts_st       (cts_st),
  .dsr_st       (dsr_st),
  .ri_st        (ri_st),
  .dcd_st       (dcd_st),
  .baud_tick_en (baud_tick_en)
);

// File: tb/uart_mctl_tb_top.sv
module uart_mctl_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic [7:0] wr_data = '0;
  logic [7:0] rd_data;
  logic [1:0] op2_pin_fn = '0;
  logic tx_shift = 1'b1, irda_tx_enc = 1'b0, rx_pin = 1'b1, irda_rx_dec = 1'b0;
  logic cts_n_pin = 1'b1, dsr_n_pin = 1'b1, ri_n_pin = 1'b1, dcd_n_pin = 1'b1;
  logic tx_pin, rx_to_shift, irda_sel, dtr_n_pin, rts_n_pin, op2_n_pin;
  logic cts_st, dsr_st, ri_st, dcd_st, baud_tick_en;

  int n_checks = 0;
  int n_fail   = 0;
  int cycles   = 0;
  bit done     = 1'b0;

  always #10 clk = ~clk;

  uart_mctl dut_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data),
    .op2_pin_fn(op2_pin_fn), .tx_shift(tx_shift), .irda_tx_enc(irda_tx_enc),
    .rx_pin(rx_pin), .irda_rx_dec(irda_rx_dec), .cts_n_pin(cts_n_pin),
    .dsr_n_pin(dsr_n_pin), .ri_n_pin(ri_n_pin), .dcd_n_pin(dcd_n_pin),
    .tx_pin(tx_pin), .rx_to_shift(rx_to_shift), .irda_sel(irda_sel),
    .dtr_n_pin(dtr_n_pin), .rts_n_pin(rts_n_pin), .op2_n_pin(op2_n_pin),
    .cts_st(cts_st), .dsr_st(dsr_st), .ri_st(ri_st), .dcd_st(dcd_st),
    .baud_tick_en(baud_tick_en)
  );

  // Vector: {reg value, op2_pin_fn, inputs, expected}
  // inputs  : tx_shift, rx_pin, irda_tx_enc, irda_rx_dec, cts_n, dsr_n, ri_n, dcd_n
  // expected: tx_pin, rx_to_shift, dtr_n, rts_n, op2_n, cts, dsr, ri, dcd, irda_sel
  localparam int NV = 8;
  localparam logic [27:0] VECS [NV] = '{
    {8'h00, 2'b00, 8'b1010_1010, 10'b1011101010},  // R3 R7 R9 plain path, idle bits
    {8'h0B, 2'b00, 8'b0101_0101, 10'b0100010100},  // R3 R4 R7 pins asserted
    {8'h0B, 2'b01, 8'b0101_0101, 10'b0100110100},  // R4 pin given to other function
    {8'h1F, 2'b00, 8'b0101_0101, 10'b1011111110},  // R5 R6 R8 loopback, all set
    {8'h14, 2'b00, 8'b1000_0000, 10'b1111100100},  // R6 R8 loopback ignores pins
    {8'h40, 2'b00, 8'b0110_1111, 10'b1011100001},  // R9 infrared path
    {8'h50, 2'b00, 8'b1001_1111, 10'b0111100001},  // R10 infrared loopback idle 0
    {8'h42, 2'b00, 8'b1001_0000, 10'b0110111111}   // R3 R7 R9 mixed
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic write_reg(input logic [7:0] v);
    @(negedge clk);
    wr_en = 1'b1;
    wr_data = v;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 5000) begin
        n_checks++;
        n_fail++;
        $display("FAIL watchdog actual=%0d expected=<5000", cycles);
        finish_run();
      end
    end
  end

  initial begin
    int ticks;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    check("R1 rd_data", 32'(rd_data), 32'h00);
    check("R1 pins", 32'({dtr_n_pin, rts_n_pin, op2_n_pin, tx_pin, irda_sel}), 32'b11110);
    check("R1 tick", 32'(baud_tick_en), 32'd1);

    // Table walk: R2 through R10
    for (int i = 0; i < NV; i++) begin
      op2_pin_fn = VECS[i][19:18];
      {tx_shift, rx_pin, irda_tx_enc, irda_rx_dec,
       cts_n_pin, dsr_n_pin, ri_n_pin, dcd_n_pin} = VECS[i][17:10];
      write_reg(VECS[i][27:20]);
      check("R2 readback", 32'(rd_data), 32'(VECS[i][27:20]));
      check("R3-R10 vector", 32'({tx_pin, rx_to_shift, dtr_n_pin, rts_n_pin, op2_n_pin,
                               cts_st, dsr_st, ri_st, dcd_st, irda_sel}),
            32'(VECS[i][9:0]));
    end

    // R8 loopback: rx_to_shift tracks tx_shift, rx_pin ignored
    op2_pin_fn = 2'b00;
    write_reg(8'h10);
    rx_pin = 1'b1;
    tx_shift = 1'b0;
    #1 check("R8 rx from tx_shift", 32'(rx_to_shift), 32'd0);
    tx_shift = 1'b1;
    rx_pin = 1'b0;
    #1 check("R8 tx_pin idle", 32'({rx_to_shift, tx_pin}), 32'b11);

    // R11 divide by four, first tick in the fourth cycle after the write
    write_reg(8'h80);
    ticks = 0;
    for (int i = 0; i < 12; i++) begin
      check("R11 tick phase", 32'(baud_tick_en), 32'((i % 4) == 3));
      if (baud_tick_en) ticks++;
      @(negedge clk);
    end
    check("R11 tick count", 32'(ticks), 32'd3);

    // R12 back to undivided, immediate ticks; then re-enter with fresh phase
    repeat (1) @(negedge clk);
    write_reg(8'h00);
    check("R12 undivided tick", 32'(baud_tick_en), 32'd1);
    @(negedge clk);
    check("R12 undivided tick next", 32'(baud_tick_en), 32'd1);
    write_reg(8'h80);
    check("R12 phase restart", 32'(baud_tick_en), 32'd0);
    repeat (3) @(negedge clk);
    check("R12 phase restart tick", 32'(baud_tick_en), 32'd1);

    // R1 reset in mid-operation clears everything
    write_reg(8'hFF);
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 reset clears", 32'(rd_data), 32'h00);
    check("R1 reset pins", 32'({dtr_n_pin, rts_n_pin, op2_n_pin, baud_tick_en}), 32'hF);

    finish_run();
  end
endmodule